// File: doc/BRIEF.md
# Synchronous Serial Byte Master

This block is the master side of a half-duplex serial port. It moves one byte per burst over a single data line that is shared between the two directions, and it addresses one of two slave ports through a pair of enable outputs. A small register bus, with a 2-bit register select and read and write strobes, carries control settings, status, the byte to send and the byte received.

A read or write of the status, transmit or receive register starts a burst of exactly eight serial clocks, provided no burst is already running. The serial clock comes from the system clock through a prescaler that divides by 2, 4, 8 or 16. The clock rests high between bursts. The data line is modelled as an output value with an output enable and a separate input. When the line is not driven, a registered keeper holds the last bit that was driven or sampled.

Register map (regSel): 0 = control, 1 = status, 2 = transmit byte, 3 = receive byte. Control bits: [1:0] divider select, [2] direction (1 = transmit, 0 = receive), [3] port select. Status bit [0] is busy.

Top module: `sync_serial_master`

## Requirements
- R1: With divider select d (control bits [1:0]), each low and each high half of the serial clock lasts 2^d system clocks, so a burst keeps the enable asserted for 16·2^d system clocks.
- R2: An access (read or write) to register 1, 2 or 3 while idle starts a burst of exactly eight rising serial clock edges.
- R3: The serial clock is high whenever no burst is active. The first falling edge comes one system clock after the starting access.
- R4: During a burst exactly one enable is high: serEn[0] when control bit 3 is 0, and serEn[1] when it is 1. It rises with the first falling clock edge and falls after the eighth high half.
- R5: Both enables are low when no burst is active.
- R6: In transmit mode (control bit 2 = 1) the byte goes out MSB first. serDataOut changes only together with a falling serial clock edge and is stable at every rising edge.
- R7: In receive mode (control bit 2 = 0), serDataIn is sampled on each rising edge, MSB first. The assembled byte is readable at register 3 after the burst.
- R8: serDataOe is high only during a transmit burst and low during receive bursts and when idle.
- R9: Status bit 0 reads 1 from the cycle after the starting access until the burst ends, and 0 otherwise.
- R10: Register accesses during a burst are ignored: control and transmit writes are dropped, and no new burst is queued.
- R11: While idle, serDataOut keeps the last driven or sampled bit, whatever serDataIn does.
- R12: A read or write of the control register (register 0) starts no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register (combinational) |
| serClk | output | 1 | Serial clock, idle high |
| serDataOut | output | 1 | Data line value (keeper when not driven) |
| serDataOe | output | 1 | Data line output enable |
| serDataIn | input | 1 | Data line input |
| serEn | output | 2 | Per-port enables, active high, idle low |

## Verification
An access sampled at edge E0 shows up at E0+1: the serial clock falls, the enable rises and the first transmit bit appears. Each rising edge then follows 2^d cycles after the falling edge before it, and the enable drops 16·2^d cycles after E0. Read data is combinational and is sampled in the same cycle as the strobe. Each scenario task drives its inputs at the falling system clock edge and samples all outputs there, half a period after the register stage that produced them. It counts low-half length, burst length and rising edges, and it rebuilds the serial byte from serDataOut at each observed rising edge.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic done;
  } ssiStrobe_t;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_STATUS = 2'd1;
  localparam logic [1:0] REG_TX     = 2'd2;
  localparam logic [1:0] REG_RX     = 2'd3;

  localparam int CTRL_DIR_BIT  = 2;
  localparam int CTRL_PORT_LSB = 3;
endpackage

// File: rtl/ssi_ctrl.sv
module ssi_ctrl
  import ssi_pkg::*;
#(
  parameter int DIV_W = 2,
  parameter int BITS  = 8,
  parameter int PORTS = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startReq,
  input  logic [DIV_W-1:0]           divSel,
  input  logic [$clog2(PORTS)-1:0]   portSel,
  output logic                       busy,
  output logic                       serClk,
  output logic [PORTS-1:0]           serEn,
  output ssiStrobe_t                 strobe
);
  localparam int MAX_HALF = 1 << ((1 << DIV_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF) + 1;
  localparam int BIT_W    = $clog2(BITS);
  localparam int PSEL_W   = $clog2(PORTS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} phase_t;

  phase_t              phase;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    halfLast;
  logic [BIT_W-1:0]    bitIdx;
  logic [PSEL_W-1:0]   portHeld;
  logic                phaseEnd;

  always_comb begin
    halfLast     = (CNT_W'(1) << divSel) - CNT_W'(1);
    phaseEnd     = (cnt == '0);
    strobe.load  = startReq && (phase == S_IDLE);
    strobe.rise  = (phase == S_LOW) && phaseEnd;
    strobe.fall  = (phase == S_HIGH) && phaseEnd && (bitIdx != LAST_BIT);
    strobe.done  = (phase == S_HIGH) && phaseEnd && (bitIdx == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= S_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      serClk   <= 1'b1;
      portHeld <= '0;
    end else if (strobe.load) begin
      phase    <= S_LOW;
      cnt      <= halfLast;
      bitIdx   <= '0;
      serClk   <= 1'b0;
      portHeld <= portSel;
    end else if (strobe.rise) begin
      phase  <= S_HIGH;
      cnt    <= halfLast;
      serClk <= 1'b1;
    end else if (strobe.fall) begin
      phase  <= S_LOW;
      cnt    <= halfLast;
      bitIdx <= bitIdx + BIT_W'(1);
      serClk <= 1'b0;
    end else if (strobe.done) begin
      phase <= S_IDLE;
      cnt   <= '0;
    end else if (phase != S_IDLE) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign busy = (phase != S_IDLE);

  for (genvar p = 0; p < PORTS; p++) begin : g_enable
    assign serEn[p] = busy && (portHeld == PSEL_W'(p));
  end

  // Checker state: rising edges seen in the current burst
  logic [BIT_W:0] riseTally;
  always_ff @(posedge clk) begin
    if (!rstN)             riseTally <= '0;
    else if (strobe.load)  riseTally <= '0;
    else if (strobe.rise)  riseTally <= riseTally + 1'b1;
  end

  a_r3_idle_clock_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serClk);
  a_r5_idle_enables_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (serEn == '0));
  a_r4_single_enable: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(serEn) == 1));
  a_r1_half_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt <= halfLast));
  a_r2_eight_rises: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |-> (riseTally == (BIT_W+1)'(BITS)));
  a_r9_busy_from_access: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !busy |=> busy);
endmodule

// File: rtl/ssi_datapath.sv
module ssi_datapath
  import ssi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 2,
  parameter int PORTS  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                regSel,
  input  logic                      regWr,
  input  logic                      regRd,
  input  logic [DATA_W-1:0]         regWdata,
  output logic [DATA_W-1:0]         regRdata,
  input  logic                      busy,
  input  ssiStrobe_t                strobe,
  input  logic                      serDataIn,
  output logic                      startReq,
  output logic [DIV_W-1:0]          divSel,
  output logic [$clog2(PORTS)-1:0]  portSel,
  output logic                      serDataOut,
  output logic                      serDataOe
);
  localparam int PSEL_W = $clog2(PORTS);

  logic                dirTx;
  logic [DATA_W-1:0]   txReg;
  logic [DATA_W-1:0]   rxReg;
  logic [DATA_W-1:0]   shiftReg;
  logic [DATA_W-1:0]   loadVal;
  logic                keeper;
  logic                ctrlWr;
  logic                txWr;

  always_comb begin
    startReq = (regWr || regRd) && (regSel != REG_CTRL);
    ctrlWr   = regWr && (regSel == REG_CTRL) && !busy;
    txWr     = regWr && (regSel == REG_TX) && !busy;
    loadVal  = txWr ? regWdata : txReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divSel  <= '0;
      dirTx   <= 1'b0;
      portSel <= '0;
      txReg   <= '0;
    end else begin
      if (ctrlWr) begin
        divSel  <= regWdata[DIV_W-1:0];
        dirTx   <= regWdata[CTRL_DIR_BIT];
        portSel <= regWdata[CTRL_PORT_LSB +: PSEL_W];
      end
      if (txWr) txReg <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      keeper   <= 1'b0;
      rxReg    <= '0;
    end else begin
      if (strobe.load) begin
        shiftReg <= loadVal;
        if (dirTx) keeper <= loadVal[DATA_W-1];
      end else if (strobe.rise) begin
        shiftReg <= {shiftReg[DATA_W-2:0], serDataIn};
        if (!dirTx) keeper <= serDataIn;
      end else if (strobe.fall) begin
        if (dirTx) keeper <= shiftReg[DATA_W-1];
      end
      if (strobe.done && !dirTx) rxReg <= shiftReg;
    end
  end

  assign serDataOut = keeper;
  assign serDataOe  = busy && dirTx;

  always_comb begin
    regRdata = '0;
    case (regSel)
      REG_CTRL: begin
        regRdata[DIV_W-1:0]                = divSel;
        regRdata[CTRL_DIR_BIT]             = dirTx;
        regRdata[CTRL_PORT_LSB +: PSEL_W]  = portSel;
      end
      REG_STATUS: regRdata[0] = busy;
      REG_TX:     regRdata    = txReg;
      default:    regRdata    = rxReg;
    endcase
  end

  a_r10_ctrl_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> ($stable(divSel) && $stable(dirTx) && $stable(portSel)));
  a_r10_tx_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(txReg));
  a_r11_keeper_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy && $past(!busy) |-> $stable(keeper));
  a_r8_oe_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    serDataOe |-> busy);
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 2,
  parameter int PORTS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              serClk,
  output logic              serDataOut,
  output logic              serDataOe,
  input  logic              serDataIn,
  output logic [PORTS-1:0]  serEn
);
  localparam int PSEL_W = $clog2(PORTS);

  ssiStrobe_t          strobe;
  logic                busy;
  logic                startReq;
  logic [DIV_W-1:0]    divSel;
  logic [PSEL_W-1:0]   portSel;

  ssi_ctrl #(.DIV_W(DIV_W), .BITS(DATA_W), .PORTS(PORTS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .divSel   (divSel),
    .portSel  (portSel),
    .busy     (busy),
    .serClk   (serClk),
    .serEn    (serEn),
    .strobe   (strobe)
  );

  ssi_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W), .PORTS(PORTS)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .regSel     (regSel),
    .regWr      (regWr),
    .regRd      (regRd),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .busy       (busy),
    .strobe     (strobe),
    .serDataIn  (serDataIn),
    .startReq   (startReq),
    .divSel     (divSel),
    .portSel    (portSel),
    .serDataOut (serDataOut),
    .serDataOe  (serDataOe)
  );

  a_r6_tx_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    serDataOe && !$stable(serDataOut) |-> $fell(serClk));
  a_r7_rx_moves_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    busy && !serDataOe && !$stable(serDataOut) |-> $rose(serClk));
  a_r12_ctrl_no_start: assert property (@(posedge clk) disable iff (!rstN)
    !busy && (regWr || regRd) && (regSel == REG_CTRL) |=> !busy);
endmodule

// File: tb/tb_sync_serial_master.sv
module tb_sync_serial_master;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       serClk, serDataOut, serDataOe;
  logic       serDataIn = 1'b0;
  logic [1:0] serEn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sync_serial_master dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .serClk(serClk),
    .serDataOut(serDataOut), .serDataOe(serDataOe), .serDataIn(serDataIn),
    .serEn(serEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one bus access from a falling edge; returns just after the capturing edge
  task automatic access(input logic [1:0] sel, input bit wr, input [7:0] data);
    @(negedge clk);
    regSel = sel; regWr = wr; regRd = !wr; regWdata = data;
    @(posedge clk); #1;
    regWr = 1'b0; regRd = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] val);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1 val = regRdata;
    @(posedge clk); #1;
    regRd = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && serEn != 0; i++) @(negedge clk);
  endtask

  // Observes a burst that was started at the last posedge
  task automatic observeBurst(input int h, input bit tx, input int port,
                              input [7:0] txB, input [7:0] slaveB, input string tag);
    int cycles = 0, rises = 0, k = 0, firstLow = 0;
    bit lowDone = 0, enOk = 1, oeOk = 1, setupOk = 1;
    logic [7:0] got = 8'h00;
    logic prevSclk = 1'b1, prevData;
    @(negedge clk);
    prevData = serDataOut;
    while (serEn != 0 && cycles < 400) begin
      if (prevSclk && !serClk && k < 8) begin
        if (!tx) serDataIn = slaveB[7-k];
        k++;
      end
      if (!prevSclk && serClk) begin
        got = {got[6:0], serDataOut};
        rises++;
        if (tx && serDataOut !== prevData) setupOk = 0;
      end
      if (!lowDone) begin
        if (!serClk) firstLow++; else lowDone = 1;
      end
      if (serEn != (2'b01 << port)) enOk = 0;
      if (serDataOe != tx) oeOk = 0;
      prevSclk = serClk;
      prevData = serDataOut;
      cycles++;
      @(negedge clk);
    end
    check({"R1 low half ", tag}, firstLow, h);
    check({"R1 burst length ", tag}, cycles, 16*h);
    check({"R2 rising edges ", tag}, rises, 8);
    check({"R4 enable select ", tag}, enOk, 1);
    check({"R8 output enable ", tag}, oeOk, 1);
    check({"R3 idle clock high ", tag}, serClk, 1);
    check({"R5 idle enables low ", tag}, serEn, 0);
    if (tx) begin
      check({"R6 tx byte msb first ", tag}, got, txB);
      check({"R6 stable at rise ", tag}, setupOk, 1);
    end else begin
      check({"R7 sampled bits ", tag}, got, slaveB);
    end
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R3 reset clock high", serClk, 1);
    check("R5 reset enables low", serEn, 0);
    check("R8 reset oe low", serDataOe, 0);
    regSel = 2'd1;
    #1 v = regRdata;
    check("R9 reset status", v, 0);
  endtask

  task automatic testTx(input int d, input int port, input [7:0] b);
    access(2'd0, 1, 8'(d | 4 | (port << 3)));
    access(2'd2, 1, b);
    observeBurst(1 << d, 1, port, b, 8'h00, "tx");
    check("R11 keeper after tx", serDataOut, b[0]);
  endtask

  task automatic testRx(input int d, input int port, input [7:0] s);
    logic [7:0] v;
    access(2'd0, 1, 8'(d | (port << 3)));
    access(2'd1, 0, 8'h00);
    observeBurst(1 << d, 0, port, 8'h00, s, "rx");
    check("R11 keeper after rx", serDataOut, s[0]);
    serDataIn = ~s[0];
    repeat (5) @(negedge clk);
    check("R11 keeper ignores input", serDataOut, s[0]);
    readReg(2'd3, v);
    check("R7 rx register", v, s);
    waitIdle();
  endtask

  task automatic testBusyIgnore();
    logic [7:0] v;
    int cyc = 0;
    access(2'd0, 1, 8'h05);
    access(2'd2, 1, 8'hF0);
    repeat (3) @(negedge clk);
    readReg(2'd1, v);
    check("R9 status busy", v, 1);
    access(2'd0, 1, 8'h0B);
    access(2'd2, 1, 8'h11);
    cyc = 0;
    while (serEn != 0 && cyc < 400) begin @(negedge clk); cyc++; end
    repeat (40) begin
      @(negedge clk);
      if (serEn != 0) cyc = 999;
    end
    check("R10 no queued burst", cyc < 400, 1);
    readReg(2'd1, v);
    check("R9 status idle", v, 0);
    observeBurst(2, 1, 0, 8'hF0, 8'h00, "ignore");
    readReg(2'd0, v);
    check("R10 control kept", v, 8'h05);
  endtask

  task automatic testCtrlOnly();
    logic [7:0] v;
    bit quiet = 1;
    access(2'd0, 1, 8'h0E);
    readReg(2'd0, v);
    check("R12 control readback", v, 8'h0E);
    repeat (20) begin
      @(negedge clk);
      if (serEn != 0 || serClk != 1) quiet = 0;
    end
    check("R12 control access no burst", quiet, 1);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testTx(0, 0, 8'hA5);
    testTx(2, 1, 8'h3C);
    testRx(1, 1, 8'h96);
    testRx(3, 0, 8'h5A);
    testBusyIgnore();
    testCtrlOnly();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule